// File: doc/BRIEF.md
# Frame and Superframe Sync Flywheel

This block sits behind the symbol detector of a line receiver. The line carries frames of a fixed number of symbols, and each frame begins with a sync pattern. The detector reports, for each symbol it delivers, whether the sync pattern has just been matched. It also reports whether the inverted superframe form of that pattern has been matched. From these flags the block finds the frame phase, confirms it, and then holds it. Isolated sync errors do not break lock. A run of consecutive errors does, and the block then starts searching again.

Once frame lock holds, the first superframe mark seen at a frame boundary fixes the superframe phase. The block then drives a square wave whose rising edge opens each superframe. A millisecond timer runs whenever frame lock is absent. If lock does not return within the allowed time, the block freezes. It then raises both a restart request and a transmitter mute, and holds them until the surrounding logic pulses a clear.

Top module: `sync_flywheel`

## Requirements
- R1: While searching, any strobed symbol with `sync_hit` or `sf_hit` set becomes the candidate frame start. `sym_pos` reads 0 for that symbol. While confirming or locked, each strobe advances `sym_pos` by one modulo FRAME_SYMS (120). `sym_pos` holds when there is no strobe and reads 0 while searching.
- R2: Frame lock (`frame_locked`=1) is declared one cycle after the checkpoint strobe that brings the count of consecutive hits to LOCK_HITS (2). The checkpoint is the strobe at which `sym_pos` wraps from 119. A miss at the checkpoint while confirming returns the block to searching.
- R3: While locked, a checkpoint counts as a hit if `sync_hit` or `sf_hit` is set. A hit clears the miss run. After UNLOCK_MISSES (6) consecutive checkpoint misses, `frame_locked` drops and searching resumes. Sync flags on strobes other than the checkpoint have no effect.
- R4: While locked, a checkpoint with `sf_hit` sets `sf_locked` and sets `frame_idx` to 0. Every other checkpoint in the confirming or locked state advances `frame_idx` modulo SF_FRAMES (8).
- R5: `sf_locked` is cleared only when frame lock is lost (or on reset or timeout). It is never 1 while `frame_locked` is 0.
- R6: `sf_wave` is 1 exactly when `sf_locked` is 1 and `frame_idx` is below SF_FRAMES/2. It is a square wave of 8 frames (12 ms) that rises at the start of the superframe.
- R7: The loss timer counts `ms_tick` pulses while the block is not locked, and clears when lock is reached. On the LOSS_MS-th (480th) tick, `restart_req` and `tx_mute` go to 1 on the next cycle and `frame_locked` is 0. If lock is reached in that same cycle, lock takes precedence.
- R8: Once halted, strobes, sync flags and ticks are ignored: `sym_pos` stays 0 and no lock occurs. A one-cycle `restart_clr` pulse returns the block to searching with the timer at zero.
- R9: After reset, all outputs are 0 and the block is searching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_stb | input | 1 | One detected symbol is delivered this cycle |
| sync_hit | input | 1 | Frame sync pattern matched at this symbol |
| sf_hit | input | 1 | Superframe sync pattern matched at this symbol |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| restart_clr | input | 1 | Pulse that releases the halted state |
| frame_locked | output | 1 | Frame lock held |
| sf_locked | output | 1 | Superframe phase known |
| sym_pos | output | 7 | Symbol position inside the frame |
| frame_idx | output | 3 | Frame number inside the superframe |
| sf_wave | output | 1 | Superframe square wave |
| restart_req | output | 1 | Cold-start request after sync loss timeout |
| tx_mute | output | 1 | Transmission stop request, raised with the restart request |

## Verification
The bench aims at the hysteresis edges. It checks that five misses keep lock and the sixth drops it; a design that counts one off would hold lock too long or drop it too early. Spurious sync flags in mid-frame are injected to catch a design that re-aligns or resets its miss count outside the checkpoint. It checks the 479th and 480th ticks of the timer, because an off-by-one there halts early or late. It also checks the halted state under a full load of strobes and flags, which exposes a design that keeps searching after a timeout. Random phases with error bursts then cross lock loss, superframe realignment and timeout repeatedly.

// File: rtl/sync_flywheel.sv
module sync_flywheel #(
  parameter int FRAME_SYMS    = 120,
  parameter int SF_FRAMES     = 8,
  parameter int LOCK_HITS     = 2,
  parameter int UNLOCK_MISSES = 6,
  parameter int LOSS_MS       = 480,
  localparam int PW = $clog2(FRAME_SYMS),
  localparam int FW = $clog2(SF_FRAMES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sym_stb,
  input  logic          sync_hit,
  input  logic          sf_hit,
  input  logic          ms_tick,
  input  logic          restart_clr,
  output logic          frame_locked,
  output logic          sf_locked,
  output logic [PW-1:0] sym_pos,
  output logic [FW-1:0] frame_idx,
  output logic          sf_wave,
  output logic          restart_req,
  output logic          tx_mute
);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int MW = $clog2(UNLOCK_MISSES + 1);
  localparam int TW = $clog2(LOSS_MS + 1);

  typedef enum logic [1:0] {ST_SEARCH, ST_CONFIRM, ST_LOCKED, ST_HALT} st_e;

  st_e           st;
  logic [PW-1:0] pos;
  logic [FW-1:0] fidx;
  logic [HW-1:0] hits;
  logic [MW-1:0] misses;
  logic [TW-1:0] tmr;
  logic          sf_lk;

  wire word_hit = sync_hit | sf_hit;
  wire tracking = (st == ST_CONFIRM) || (st == ST_LOCKED);
  wire at_chk   = tracking && sym_stb && (pos == PW'(FRAME_SYMS - 1));
  wire lock_now = (st == ST_CONFIRM) && at_chk && word_hit && (hits == HW'(LOCK_HITS - 1));
  wire hunting  = (st == ST_SEARCH) || (st == ST_CONFIRM);
  wire timeout  = hunting && ms_tick && (tmr == TW'(LOSS_MS - 1)) && !lock_now;
  wire [FW-1:0] fidx_inc = (fidx == FW'(SF_FRAMES - 1)) ? '0 : fidx + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_SEARCH;
      pos    <= '0;
      fidx   <= '0;
      hits   <= '0;
      misses <= '0;
      tmr    <= '0;
      sf_lk  <= 1'b0;
    end else begin
      case (st)
        ST_SEARCH: begin
          if (sym_stb && word_hit) begin
            st   <= ST_CONFIRM;
            pos  <= '0;
            fidx <= '0;
            hits <= HW'(1);
          end
        end
        ST_CONFIRM: begin
          if (at_chk) begin
            pos <= '0;
            if (word_hit) begin
              fidx <= fidx_inc;
              hits <= hits + 1'b1;
              if (lock_now) begin
                st     <= ST_LOCKED;
                misses <= '0;
              end
            end else begin
              st   <= ST_SEARCH;
              fidx <= '0;
              hits <= '0;
            end
          end else if (sym_stb) begin
            pos <= pos + 1'b1;
          end
        end
        ST_LOCKED: begin
          if (at_chk) begin
            pos <= '0;
            if (sf_hit) begin
              fidx  <= '0;
              sf_lk <= 1'b1;
            end else begin
              fidx <= fidx_inc;
            end
            if (word_hit) begin
              misses <= '0;
            end else if (misses == MW'(UNLOCK_MISSES - 1)) begin
              st     <= ST_SEARCH;
              misses <= '0;
              hits   <= '0;
              fidx   <= '0;
              sf_lk  <= 1'b0;
            end else begin
              misses <= misses + 1'b1;
            end
          end else if (sym_stb) begin
            pos <= pos + 1'b1;
          end
        end
        default: begin
          if (restart_clr) st <= ST_SEARCH;
        end
      endcase

      if (hunting && !lock_now) begin
        if (timeout) begin
          st   <= ST_HALT;
          tmr  <= '0;
          pos  <= '0;
          fidx <= '0;
          hits <= '0;
        end else if (ms_tick) begin
          tmr <= tmr + 1'b1;
        end
      end else begin
        tmr <= '0;
      end
    end
  end

  assign frame_locked = (st == ST_LOCKED);
  assign sf_locked    = sf_lk;
  assign sym_pos      = pos;
  assign frame_idx    = fidx;
  assign sf_wave      = sf_lk && (fidx < FW'(SF_FRAMES / 2));
  assign restart_req  = (st == ST_HALT);
  assign tx_mute      = (st == ST_HALT);
endmodule

// File: rtl/sync_flywheel_chk.sv
module sync_flywheel_chk #(
  parameter int FRAME_SYMS = 120,
  parameter int SF_FRAMES  = 8,
  localparam int PW = $clog2(FRAME_SYMS),
  localparam int FW = $clog2(SF_FRAMES)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sym_stb,
  input logic          sync_hit,
  input logic          sf_hit,
  input logic          ms_tick,
  input logic          restart_clr,
  input logic          frame_locked,
  input logic          sf_locked,
  input logic [PW-1:0] sym_pos,
  input logic [FW-1:0] frame_idx,
  input logic          sf_wave,
  input logic          restart_req,
  input logic          tx_mute
);
  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_locked && $past(frame_locked) && $past(sym_stb)) |->
      (int'(sym_pos) == (int'($past(sym_pos)) + 1) % FRAME_SYMS)); // R1
  AST_POS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_locked && $past(frame_locked) && !$past(sym_stb)) |-> $stable(sym_pos)); // R1
  AST_LOCK_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_locked) |-> $past(sym_stb && (sync_hit || sf_hit))); // R2
  AST_SF_NEEDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    sf_locked |-> frame_locked); // R5
  AST_SF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(sf_locked) && frame_locked) |-> sf_locked); // R5
  AST_WAVE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    sf_wave |-> sf_locked); // R6
  AST_TIMEOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(restart_req) |-> ($past(ms_tick) && !frame_locked)); // R7
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (restart_req && !restart_clr) |=> restart_req); // R8
endmodule

bind sync_flywheel sync_flywheel_chk #(.FRAME_SYMS(FRAME_SYMS), .SF_FRAMES(SF_FRAMES)) u_chk (.*);

// File: tb/test_sync_flywheel.sv
module test_sync_flywheel;
  localparam int CLK_PERIOD = 10;
  localparam int FS = 120, SFN = 8, LH = 2, UM = 6, LMS = 480;

  logic clk = 0, rst_n = 0;
  logic sym_stb = 0, sync_hit = 0, sf_hit = 0, ms_tick = 0, restart_clr = 0;
  logic frame_locked, sf_locked, sf_wave, restart_req, tx_mute;
  logic [6:0] sym_pos;
  logic [2:0] frame_idx;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  sync_flywheel i_sync_flywheel (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference model state
  int m_st, m_pos, m_fidx, m_hits, m_miss, m_tmr;
  bit m_sf;

  task automatic m_reset();
    m_st = 0; m_pos = 0; m_fidx = 0; m_hits = 0; m_miss = 0; m_tmr = 0; m_sf = 0;
  endtask

  task automatic m_step(input bit stb, input bit sh, input bit sf, input bit tk, input bit clr);
    int old = m_st;
    bit word = sh | sf;
    bit cp = (old == 1 || old == 2) && stb && (m_pos == FS-1);
    bit locking = (old == 1) && cp && word && (m_hits + 1 == LH);
    if (old == 0) begin
      if (stb && word) begin m_st = 1; m_pos = 0; m_fidx = 0; m_hits = 1; end
    end else if (old == 1) begin
      if (cp) begin
        m_pos = 0;
        if (word) begin
          m_fidx = (m_fidx + 1) % SFN; m_hits++;
          if (locking) begin m_st = 2; m_miss = 0; end
        end else begin m_st = 0; m_fidx = 0; m_hits = 0; end
      end else if (stb) m_pos++;
    end else if (old == 2) begin
      if (cp) begin
        m_pos = 0;
        if (sf) begin m_fidx = 0; m_sf = 1; end else m_fidx = (m_fidx + 1) % SFN;
        if (word) m_miss = 0;
        else if (m_miss + 1 == UM) begin m_st = 0; m_miss = 0; m_hits = 0; m_fidx = 0; m_sf = 0; end
        else m_miss++;
      end else if (stb) m_pos++;
    end else if (clr) m_st = 0;
    if ((old == 0 || old == 1) && !locking) begin
      if (tk && m_tmr == LMS-1) begin m_st = 3; m_tmr = 0; m_pos = 0; m_fidx = 0; m_hits = 0; end
      else if (tk) m_tmr++;
    end else m_tmr = 0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
    end
  endtask

  task automatic compare_all();
    chk("R2/R3 frame_locked", frame_locked, m_st == 2);
    chk("R4/R5 sf_locked", sf_locked, m_sf);
    chk("R1 sym_pos", sym_pos, m_pos);
    chk("R4 frame_idx", frame_idx, m_fidx);
    chk("R6 sf_wave", sf_wave, m_sf && m_fidx < SFN/2);
    chk("R7/R8 restart_req", restart_req, m_st == 3);
    chk("R7 tx_mute", tx_mute, m_st == 3);
  endtask

  task automatic cyc(input bit stb, input bit sh, input bit sf, input bit tk, input bit clr);
    @(negedge clk);
    compare_all();
    sym_stb = stb; sync_hit = sh; sf_hit = sf; ms_tick = tk; restart_clr = clr;
    m_step(stb, sh, sf, tk, clr);
  endtask

  task automatic settle();
    cyc(0, 0, 0, 0, 0);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; sym_stb = 0; sync_hit = 0; sf_hit = 0; ms_tick = 0; restart_clr = 0;
    m_reset();
    repeat (2) @(negedge clk);
    rst_n = 1;
    m_step(0, 0, 0, 0, 0);
  endtask

  // one frame of strobes after a checkpoint; last strobe is the next checkpoint
  task automatic frame(input bit hit, input bit sf, input bit spur);
    for (int i = 0; i < FS-1; i++) cyc(1, spur && (i == 50), 0, 0, 0);
    cyc(1, hit && !sf, sf, 0, 0);
  endtask

  // random line generator
  int lp = 0, fr = 0;
  task automatic rnd_phase(input int cycles, input int stb_pct, input int err_pct,
                           input int spur_per_k, input int tick_div, input int clr_div);
    for (int c = 0; c < cycles; c++) begin
      bit stb = ($urandom % 100) < stb_pct;
      bit sh = 0, sf = 0, tk, clr;
      if (stb) begin
        if (lp == 0) begin
          bit ok = ($urandom % 100) >= err_pct;
          if (ok && fr == 0 && ($urandom % 4 != 0)) sf = 1;
          else sh = ok;
          fr = (fr + 1) % SFN;
        end else sh = ($urandom % 1000) < spur_per_k;
        lp = (lp + 1) % FS;
      end
      tk = (tick_div > 0) && ($urandom % tick_div == 0);
      clr = (m_st == 3) && ($urandom % clr_div == 0);
      cyc(stb, sh, sf, tk, clr);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d2c));
    m_reset();
    do_reset();
    @(negedge clk);
    // R9 reset state
    chk("R9 reset frame_locked", frame_locked, 0);
    chk("R9 reset restart_req", restart_req, 0);
    chk("R9 reset sym_pos", sym_pos, 0);

    // R2: candidate then miss returns to search
    cyc(1, 1, 0, 0, 0);
    frame(0, 0, 0);
    settle();
    chk("R2 miss at confirm keeps unlocked", frame_locked, 0);
    chk("R1 searching sym_pos", sym_pos, 0);

    // R2: lock on second hit
    cyc(1, 1, 0, 0, 0);
    frame(1, 0, 1);
    settle();
    chk("R2 locked after two hits", frame_locked, 1);

    // R3: five misses keep lock, hit resets, six misses drop
    for (int k = 0; k < UM-1; k++) frame(0, 0, 1);
    settle();
    chk("R3 locked after five misses", frame_locked, 1);
    frame(1, 0, 0);
    for (int k = 0; k < UM-1; k++) frame(0, 0, 0);
    settle();
    chk("R3 hit cleared miss run", frame_locked, 1);
    frame(0, 0, 0);
    settle();
    chk("R3 unlocked after six misses", frame_locked, 0);

    // R4/R6: superframe lock and square wave
    cyc(1, 1, 0, 0, 0);
    frame(1, 0, 0);
    frame(1, 0, 0);
    settle();
    chk("R4 no superframe lock yet", sf_locked, 0);
    frame(1, 1, 0);
    settle();
    chk("R4 superframe locked", sf_locked, 1);
    chk("R4 frame_idx zero at superframe", frame_idx, 0);
    chk("R6 wave high at superframe start", sf_wave, 1);
    for (int k = 0; k < 4; k++) frame(1, 0, 0);
    settle();
    chk("R6 wave low in second half", sf_wave, 0);
    chk("R4 frame_idx four", frame_idx, 4);
    for (int k = 0; k < UM; k++) frame(0, 0, 0);
    settle();
    chk("R5 superframe lock cleared with frame lock", sf_locked, 0);

    // R7/R8: timeout
    do_reset();
    for (int k = 0; k < LMS-1; k++) cyc(0, 0, 0, 1, 0);
    settle();
    chk("R7 no halt after 479 ticks", restart_req, 0);
    cyc(0, 0, 0, 1, 0);
    settle();
    chk("R7 halt after 480th tick", restart_req, 1);
    chk("R7 tx_mute with halt", tx_mute, 1);
    for (int k = 0; k < 400; k++) cyc(1, 1, k[0], 1, 0);
    settle();
    chk("R8 halted ignores inputs", restart_req, 1);
    chk("R8 halted sym_pos", sym_pos, 0);
    chk("R8 halted no lock", frame_locked, 0);
    cyc(0, 0, 0, 0, 1);
    settle();
    chk("R8 clear releases halt", restart_req, 0);

    // random phases
    do_reset();
    lp = 0; fr = 0;
    rnd_phase(3000, 100, 0, 0, 0, 20);
    rnd_phase(30000, 70, 20, 5, 300, 40);
    rnd_phase(15000, 80, 85, 20, 3, 30);
    rnd_phase(40000, 75, 40, 10, 60, 25);
    settle();

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule